// File: doc/BRIEF.md
# Working-Register Address Translator

This block converts the short register operands of an 8-bit processor into full 8-bit register-file addresses. Two base pointers, each holding five significant upper bits, mark two 8-byte windows in the register file. A working-register operand names one byte inside one of those windows. The top bit of its 4-bit field picks the window, and the lower three bits pick the byte.

The translator accepts an operand in two forms. In the 8-bit form, a logical address whose upper nibble is 1100b is treated as a working-register escape, and its low nibble is translated. Any other 8-bit value passes through as a direct register address. In the 4-bit form, the nibble is translated directly. A register-pair variant of either working form yields the even address of one of four aligned pairs in the selected window.

The pointers are written through their own write strobes. They are read back on dedicated outputs, and their low three bits always read as zero. Translation is combinational from the operand inputs and the current pointer contents.

Top module: `wra_unit`

## Requirements
- R1: When `nib_mode` is 0 and `op_addr[7:4]` is not 1100b, `phys_addr` equals `op_addr` and `wreg_hit` is 0.
- R2: When `nib_mode` is 0 and `op_addr[7:4]` is 1100b, `wreg_hit` is 1 and the address is translated from `op_addr[3:0]`.
- R3: The field bit 3 selects the pointer: 0 selects pointer 0 (`rp0_q`) and 1 selects pointer 1 (`rp1_q`).
- R4: In the single-register form, `phys_addr` is the selected pointer bits [7:3] followed by field bits [2:0]. For example, with pointer 1 = A8h and `op_addr` = CBh, the result is ABh.
- R5: A synchronous reset sets `rp0_q` to C0h and `rp1_q` to C8h, and it takes priority over a pointer write in the same cycle.
- R6: With `pair_mode` = 1 on a working-register operand, `phys_addr` is the selected pointer bits [7:3], then field bits [2:1], then bit 0 forced to 0.
- R7: Bits [2:0] of `rp0_q` and `rp1_q` read as 0 whatever value was written.
- R8: A pointer write with `rp0_wr` or `rp1_wr` takes effect at the next rising clock edge. A translation in the cycle of the write still uses the previous pointer value.
- R9: With `nib_mode` = 1, `op_nib` is translated the same way as the low nibble of an escape, `wreg_hit` is 1, and `op_addr` has no effect.
- R10: `pair_mode` has no effect on a direct (non-escape) 8-bit address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_addr | input | 8 | 8-bit logical register address from the instruction |
| op_nib | input | 4 | 4-bit working-register field |
| nib_mode | input | 1 | 1: translate `op_nib`; 0: use the 8-bit form |
| pair_mode | input | 1 | 1: register-pair form for working operands |
| rp0_wr | input | 1 | Write strobe for pointer 0 |
| rp1_wr | input | 1 | Write strobe for pointer 1 |
| rp_wdata | input | 8 | Pointer write data (bits [7:3] kept) |
| phys_addr | output | 8 | Physical register-file address |
| wreg_hit | output | 1 | Working-register addressing detected |
| rp0_q | output | 8 | Pointer 0 readback |
| rp1_q | output | 8 | Pointer 1 readback |

## Verification
On every cycle, the assertions check the direct pass-through, the pointer choice by field bit 3, the low-bit composition in both the single and the pair form, the zero low pointer bits, and that a write shows on the readback one edge later. Only the bench scenarios show the following: the exact reset values and the priority of reset over a write, the old pointer being used during the write cycle, the worked example yielding ABh, and that `op_addr` is ignored in nibble mode. The bench also sweeps all 256 logical addresses against its reference model.

// File: rtl/wra_pkg.sv
package wra_pkg;

    localparam int ADDR_W  = 8;
    localparam int FIELD_W = 4;
    localparam int LO_W    = 3;
    localparam int HI_W    = ADDR_W - LO_W;
    localparam int NPTR    = 2;
    localparam logic [FIELD_W-1:0] ESC_CODE = 4'b1100;

    typedef enum logic [1:0] {
        FORM_DIRECT = 2'd0,
        FORM_WREG   = 2'd1,
        FORM_WPAIR  = 2'd2
    } form_e;

    typedef struct packed {
        form_e             form;
        logic              ptr_idx;
        logic [LO_W-1:0]   low;
        logic [ADDR_W-1:0] direct;
    } xlate_req_t;

    function automatic logic is_escape(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: FIELD_W] == ESC_CODE;
    endfunction

    function automatic logic [ADDR_W-1:0] compose(input logic [HI_W-1:0] hi,
                                                  input logic [LO_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/wra_ptr_bank.sv
module wra_ptr_bank
    import wra_pkg::*;
#(
    parameter int                     N    = NPTR,
    parameter logic [N*ADDR_W-1:0]    INIT = {8'hC8, 8'hC0}
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N-1:0]                  we,
    input  logic [ADDR_W-1:0]             wdata,
    output logic [N-1:0][ADDR_W-1:0]      ptr_q
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_ptr
            logic [HI_W-1:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst)
                    hi_q <= INIT[i*ADDR_W+LO_W +: HI_W];
                else if (we[i])
                    hi_q <= wdata[ADDR_W-1:LO_W];
            end
            assign ptr_q[i] = compose(hi_q, '0);
        end
    endgenerate
endmodule

// File: rtl/wra_field_pick.sv
module wra_field_pick
    import wra_pkg::*;
(
    input  logic [ADDR_W-1:0]  op_addr,
    input  logic [FIELD_W-1:0] op_nib,
    input  logic               nib_mode,
    input  logic               pair_mode,
    output xlate_req_t         req
);
    logic [FIELD_W-1:0] field;

    always_comb begin
        field       = nib_mode ? op_nib : op_addr[FIELD_W-1:0];
        req.ptr_idx = field[FIELD_W-1];
        req.low     = field[LO_W-1:0];
        req.direct  = op_addr;
        if (nib_mode || is_escape(op_addr))
            req.form = pair_mode ? FORM_WPAIR : FORM_WREG;
        else
            req.form = FORM_DIRECT;
    end
endmodule

// File: rtl/wra_addr_form.sv
module wra_addr_form
    import wra_pkg::*;
#(
    parameter int N = NPTR
) (
    input  xlate_req_t                req,
    input  logic [N-1:0][ADDR_W-1:0]  ptr_q,
    output logic [ADDR_W-1:0]         phys,
    output logic                      hit
);
    logic [HI_W-1:0] base;

    always_comb begin
        base = ptr_q[req.ptr_idx][ADDR_W-1:LO_W];
        unique case (req.form)
            FORM_WREG: begin
                phys = compose(base, req.low);
                hit  = 1'b1;
            end
            FORM_WPAIR: begin
                phys = compose(base, {req.low[LO_W-1:1], 1'b0});
                hit  = 1'b1;
            end
            default: begin
                phys = req.direct;
                hit  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wra_unit.sv
module wra_unit
    import wra_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RP0_INIT = 8'hC0,
    parameter logic [ADDR_W-1:0] RP1_INIT = 8'hC8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         op_addr,
    input  logic [3:0]         op_nib,
    input  logic               nib_mode,
    input  logic               pair_mode,
    input  logic               rp0_wr,
    input  logic               rp1_wr,
    input  logic [7:0]         rp_wdata,
    output logic [7:0]         phys_addr,
    output logic               wreg_hit,
    output logic [7:0]         rp0_q,
    output logic [7:0]         rp1_q
);
    logic [NPTR-1:0][ADDR_W-1:0] ptr_q;
    xlate_req_t                  req;

    wra_ptr_bank #(
        .N    (NPTR),
        .INIT ({RP1_INIT, RP0_INIT})
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    ({rp1_wr, rp0_wr}),
        .wdata (rp_wdata),
        .ptr_q (ptr_q)
    );

    wra_field_pick u_pick (
        .op_addr   (op_addr),
        .op_nib    (op_nib),
        .nib_mode  (nib_mode),
        .pair_mode (pair_mode),
        .req       (req)
    );

    wra_addr_form #(.N(NPTR)) u_form (
        .req   (req),
        .ptr_q (ptr_q),
        .phys  (phys_addr),
        .hit   (wreg_hit)
    );

    assign rp0_q = ptr_q[0];
    assign rp1_q = ptr_q[1];
endmodule

// File: rtl/wra_unit_chk.sv
module wra_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] op_addr,
    input logic [3:0] op_nib,
    input logic       nib_mode,
    input logic       pair_mode,
    input logic       rp0_wr,
    input logic       rp1_wr,
    input logic [7:0] rp_wdata,
    input logic [7:0] phys_addr,
    input logic       wreg_hit,
    input logic [7:0] rp0_q,
    input logic [7:0] rp1_q
);
    logic [3:0] fld;
    logic       esc;
    logic [7:0] sel_ptr;
    assign fld     = nib_mode ? op_nib : op_addr[3:0];
    assign esc     = nib_mode || (op_addr[7:4] == 4'b1100);
    assign sel_ptr = fld[3] ? rp1_q : rp0_q;

    // R1, R10
    a_r1_direct_pass: assert property (@(posedge clk) disable iff (rst)
        !esc |-> (phys_addr == op_addr) && !wreg_hit);

    // R2, R9
    a_r2_escape_hit: assert property (@(posedge clk) disable iff (rst)
        esc |-> wreg_hit);

    // R3
    a_r3_ptr_select: assert property (@(posedge clk) disable iff (rst)
        esc |-> phys_addr[7:3] == sel_ptr[7:3]);

    // R4
    a_r4_low_bits: assert property (@(posedge clk) disable iff (rst)
        (esc && !pair_mode) |-> phys_addr[2:0] == fld[2:0]);

    // R6
    a_r6_pair_even: assert property (@(posedge clk) disable iff (rst)
        (esc && pair_mode) |-> (phys_addr[2:1] == fld[2:1]) && !phys_addr[0]);

    // R7
    a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
        (rp0_q[2:0] == 3'b000) && (rp1_q[2:0] == 3'b000));

    // R8
    a_r8_wr_next0: assert property (@(posedge clk) disable iff (rst)
        (rp0_wr && !rst) |=> rp0_q[7:3] == $past(rp_wdata[7:3]));

    a_r8_wr_next1: assert property (@(posedge clk) disable iff (rst)
        (rp1_wr && !rst) |=> rp1_q[7:3] == $past(rp_wdata[7:3]));
endmodule

bind wra_unit wra_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_addr   (op_addr),
    .op_nib    (op_nib),
    .nib_mode  (nib_mode),
    .pair_mode (pair_mode),
    .rp0_wr    (rp0_wr),
    .rp1_wr    (rp1_wr),
    .rp_wdata  (rp_wdata),
    .phys_addr (phys_addr),
    .wreg_hit  (wreg_hit),
    .rp0_q     (rp0_q),
    .rp1_q     (rp1_q)
);

// File: tb/wra_unit_test.sv
`timescale 1ns/1ps
module wra_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_addr = '0;
    logic [3:0] op_nib = '0;
    logic       nib_mode = 1'b0;
    logic       pair_mode = 1'b0;
    logic       rp0_wr = 1'b0;
    logic       rp1_wr = 1'b0;
    logic [7:0] rp_wdata = '0;
    logic [7:0] phys_addr;
    logic       wreg_hit;
    logic [7:0] rp0_q;
    logic [7:0] rp1_q;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int m_rp0, m_rp1;

    always #4 clk = ~clk;

    wra_unit uut (
        .clk(clk), .rst(rst), .op_addr(op_addr), .op_nib(op_nib),
        .nib_mode(nib_mode), .pair_mode(pair_mode), .rp0_wr(rp0_wr),
        .rp1_wr(rp1_wr), .rp_wdata(rp_wdata), .phys_addr(phys_addr),
        .wreg_hit(wreg_hit), .rp0_q(rp0_q), .rp1_q(rp1_q)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Inputs are applied just after a rising edge, outputs compared at the
    // falling edge, and the model pointers follow the next rising edge.
    task automatic step(input string tag, input int a, input int nb,
                        input bit nm, input bit pm, input bit w0,
                        input bit w1, input int wd);
        int fld, ptr, exp_phys, exp_hit;
        op_addr = a[7:0]; op_nib = nb[3:0]; nib_mode = nm; pair_mode = pm;
        rp0_wr = w0; rp1_wr = w1; rp_wdata = wd[7:0];
        @(negedge clk);
        fld = nm ? (nb & 15) : (a & 15);
        if (nm || ((a >> 4) & 15) == 12) begin
            ptr      = (fld >= 8) ? m_rp1 : m_rp0;
            exp_phys = (ptr & 'hF8) | (pm ? (fld & 6) : (fld & 7));
            exp_hit  = 1;
        end else begin
            exp_phys = a & 255;
            exp_hit  = 0;
        end
        check({tag, " phys_addr"}, int'(phys_addr), exp_phys);
        check({tag, " wreg_hit"}, int'(wreg_hit), exp_hit);
        check({tag, " rp0_q"}, int'(rp0_q), m_rp0);
        check({tag, " rp1_q"}, int'(rp1_q), m_rp1);
        @(posedge clk);
        if (w0) m_rp0 = wd & 'hF8;
        if (w1) m_rp1 = wd & 'hF8;
        #1;
        rp0_wr = 1'b0; rp1_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_rp0 = 'hC0; m_rp1 = 'hC8;
        rp0_wr = 1'b1; rp_wdata = 8'h55;       // ignored under reset
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; rp0_wr = 1'b0;

        // R5 reset values
        step("R5 reset", 'hC3, 0, 0, 0, 0, 0, 0);
        // R1 direct addresses
        step("R1 direct", 'h12, 0, 0, 0, 0, 0, 0);
        step("R1 direct", 'hD9, 0, 0, 0, 0, 0, 0);
        // R7 low bits dropped, R8 old value used in write cycle
        step("R8 same-cycle rp1", 'hCB, 0, 0, 0, 0, 1, 'hAF);
        // R4 worked example: pointer 1 = A8h, CBh -> ABh
        step("R4 example", 'hCB, 0, 0, 0, 0, 0, 0);
        check("R4 example literal", int'(phys_addr), 'hAB);
        check("R7 rp1 low zero", int'(rp1_q & 7), 0);
        step("R8 same-cycle rp0", 'hC5, 0, 0, 0, 1, 0, 'h37);
        step("R3 ptr0 select", 'hC5, 0, 0, 0, 0, 0, 0);
        step("R3 ptr1 select", 'hCD, 0, 0, 0, 0, 0, 0);
        // R2 sweep of every 8-bit address, both pair settings
        for (int a = 0; a < 256; a++) begin
            step("R2 sweep", a, 0, 0, 0, 0, 0, 0);
            step("R6 sweep", a, 0, 0, 1, 0, 0, 0);
        end
        // R10 pair flag on direct addresses
        step("R10 pair ignored", 'h47, 0, 0, 1, 0, 0, 0);
        step("R10 pair ignored", 'hFF, 0, 0, 1, 0, 0, 0);
        // R9 nibble form; op_addr varies without effect
        for (int n = 0; n < 16; n++) begin
            step("R9 nibble", 'h00, n, 1, 0, 0, 0, 0);
            step("R9 nibble addr ignored", 'hE5, n, 1, 0, 0, 0, 0);
            step("R6 nibble pair", 'h31, n, 1, 1, 0, 0, 0);
        end
        // R6 explicit pair example: ptr1 = A8h, field 1111b -> AEh
        step("R6 pair", 'h00, 'hF, 1, 1, 0, 0, 0);
        check("R6 pair literal", int'(phys_addr), 'hAE);
        // R7 write all-ones
        step("R7 write FF", 'h00, 0, 0, 0, 1, 1, 'hFF);
        step("R7 readback", 'hC7, 0, 0, 0, 0, 0, 0);
        // R5 reset overrides a simultaneous write
        rst = 1'b1; rp0_wr = 1'b1; rp1_wr = 1'b1; rp_wdata = 8'h10;
        @(posedge clk);
        #1 rst = 1'b0; rp0_wr = 1'b0; rp1_wr = 1'b0;
        m_rp0 = 'hC0; m_rp1 = 'hC8;
        step("R5 reset over write", 'hCA, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule